// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against. One value is the empty offset and the other is the full offset. It drives both values continuously to that flag logic. The block does not store FIFO data and does not produce any flag.

A master reset fixes the loading method and puts a default value into both offsets. In the serial method, `serIn` is shifted in by one bit on each write-clock edge while `serEn` is high. The bit order runs through one combined chain that covers both offsets. In the parallel method, each write-clock edge with both `loadEn` and `wrEn` high writes `dataIn` into the next bus-sized part of the offsets. The offsets can be read back over `dataOut` in the read-clock domain by the same part order, whichever method was chosen.

Top module: `ofs_loader`

## Requirements
- R1: On each write-clock edge with `mrst` high, the loading method is captured from `serialMode` (1 = serial, 0 = parallel). While `mrst` is low, changes on `serialMode` have no effect.
- R2: In the serial method, each write-clock edge with `serEn` high shifts in `serIn`. After 2*OFS_W shifts (30 by default), the first bit is in `emptyOfs[0]` and the last bit is in `fullOfs[OFS_W-1]`. Bits move from the full offset down into the empty offset.
- R3: In the serial method, write edges with `loadEn` and `wrEn` both high leave the offsets unchanged. In the parallel method, `serEn` leaves the offsets unchanged.
- R4: In the parallel method, successive writes fill four parts in this order:
  - index 0: `emptyOfs[8:0]` from `dataIn[8:0]`;
  - index 1: `emptyOfs[14:9]` from `dataIn[5:0]`;
  - index 2: `fullOfs[8:0]` from `dataIn[8:0]`;
  - index 3: `fullOfs[14:9]` from `dataIn[5:0]`.
  After index 3 the write index wraps to 0.
- R5: A parallel write happens only when `loadEn` and `wrEn` are both high. Either one alone changes nothing.
- R6: A write-clock edge with `mrst` high sets both offsets to DEF_OFS (1023 by default) and clears the write index. A read-clock edge with `mrst` high clears the read index and sets `dataOut` to 0.
- R7: Each read-clock edge with `loadEn` and `rdEn` both high loads `dataOut` with the part at the read index, zero-extended to 9 bits. It then advances the read index through the R4 order and wraps after index 3. This works in either method.
- R8: `dataOut` holds its value on read-clock edges without a read step.
- R9: Reading back never alters either offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, synchronous to each clock |
| serialMode | input | 1 | Method select, captured during master reset |
| serEn | input | 1 | Serial shift enable |
| serIn | input | 1 | Serial data bit |
| loadEn | input | 1 | Offset access select, shared by parallel write and readback |
| wrEn | input | 1 | Write enable |
| rdEn | input | 1 | Read enable |
| dataIn | input | 9 | Parallel write data |
| dataOut | output | 9 | Readback data |
| emptyOfs | output | 15 | Empty offset to flag logic |
| fullOfs | output | 15 | Full offset to flag logic |

## Verification
The offsets appear directly on the ports, so a wrong write index or wrong shift direction shows up on `emptyOfs` or `fullOfs` right after the faulty write edge. A mis-latched method shows up as ignored loads or spurious changes on the next write edge. A read-index error shows up on `dataOut` one read-clock edge after the faulty step. The wrap cases only show up on the fifth write and the fifth read.

// File: rtl/ofs_loader_pkg.sv
package ofs_loader_pkg;

  localparam int PART_CNT = 4;
  localparam int IDX_W    = $clog2(PART_CNT);

  // write-domain strobes from control to datapath
  typedef struct packed {
    logic             loadDef;
    logic             shift;
    logic             parWr;
    logic [IDX_W-1:0] wrSel;
  } wrStrb_t;

  // read-domain strobes from control to datapath
  typedef struct packed {
    logic             clear;
    logic             step;
    logic [IDX_W-1:0] rdSel;
  } rdStrb_t;

endpackage

// File: rtl/ofs_loader_ctrl.sv
module ofs_loader_ctrl
  import ofs_loader_pkg::*;
(
  input  logic    wrClk,
  input  logic    rdClk,
  input  logic    mrst,
  input  logic    serialMode,
  input  logic    serEn,
  input  logic    loadEn,
  input  logic    wrEn,
  input  logic    rdEn,
  output wrStrb_t wrStrb,
  output rdStrb_t rdStrb
);

  logic             methodSerial;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;

  // method capture and write index (write domain)
  always_ff @(posedge wrClk) begin
    if (mrst) begin
      methodSerial <= serialMode;
      wrIdx        <= '0;
    end else if (wrStrb.parWr) begin
      wrIdx <= wrIdx + 1'b1;
    end
  end

  always_comb begin
    wrStrb.loadDef = mrst;
    wrStrb.shift   = !mrst && methodSerial && serEn;
    wrStrb.parWr   = !mrst && !methodSerial && loadEn && wrEn;
    wrStrb.wrSel   = wrIdx;
  end

  // readback index (read domain)
  always_ff @(posedge rdClk) begin
    if (mrst)             rdIdx <= '0;
    else if (rdStrb.step) rdIdx <= rdIdx + 1'b1;
  end

  always_comb begin
    rdStrb.clear = mrst;
    rdStrb.step  = !mrst && loadEn && rdEn;
    rdStrb.rdSel = rdIdx;
  end

  // R1: method only changes under master reset
  p_method_locked_r1: assert property (@(posedge wrClk) disable iff (mrst)
    !mrst |=> $stable(methodSerial));

  // R4: write index wraps after the last part
  p_wr_wrap_r4: assert property (@(posedge wrClk) disable iff (mrst)
    (wrStrb.parWr && wrIdx == IDX_W'(PART_CNT-1)) |=> (wrIdx == '0));

  // R3: the two methods never act on the same edge
  p_one_method_r3: assert property (@(posedge wrClk) disable iff (mrst)
    !(wrStrb.shift && wrStrb.parWr));

  // R7: read index wraps after the last part
  p_rd_wrap_r7: assert property (@(posedge rdClk) disable iff (mrst)
    (rdStrb.step && rdIdx == IDX_W'(PART_CNT-1)) |=> (rdIdx == '0));

endmodule

// File: rtl/ofs_loader_dp.sv
module ofs_loader_dp
  import ofs_loader_pkg::*;
#(
  parameter int OFS_W   = 15,
  parameter int BUS_W   = 9,
  parameter int DEF_OFS = 1023
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  wrStrb_t          wrStrb,
  input  rdStrb_t          rdStrb,
  input  logic             serIn,
  input  logic [BUS_W-1:0] dataIn,
  output logic [BUS_W-1:0] dataOut,
  output logic [OFS_W-1:0] emptyOfs,
  output logic [OFS_W-1:0] fullOfs
);

  localparam int LO_W  = BUS_W;
  localparam int HI_W  = OFS_W - BUS_W;
  localparam int TOT_W = 2 * OFS_W;
  localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEF_OFS);

  // combined chain: {full, empty}
  logic [TOT_W-1:0] ofsReg;
  logic [TOT_W-1:0] ofsNext;

  always_comb begin
    ofsNext = ofsReg;
    if (wrStrb.shift) begin
      ofsNext = {serIn, ofsReg[TOT_W-1:1]};
    end else if (wrStrb.parWr) begin
      case (wrStrb.wrSel)
        2'd0: ofsNext[LO_W-1:0]             = dataIn[LO_W-1:0];
        2'd1: ofsNext[OFS_W-1:LO_W]         = dataIn[HI_W-1:0];
        2'd2: ofsNext[OFS_W+LO_W-1:OFS_W]   = dataIn[LO_W-1:0];
        default: ofsNext[TOT_W-1:OFS_W+LO_W] = dataIn[HI_W-1:0];
      endcase
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrStrb.loadDef) ofsReg <= {DEF_V, DEF_V};
    else                ofsReg <= ofsNext;
  end

  assign emptyOfs = ofsReg[OFS_W-1:0];
  assign fullOfs  = ofsReg[TOT_W-1:OFS_W];

  // readback parts, zero-extended to the bus
  logic [BUS_W-1:0] partVal [PART_CNT];

  for (genvar k = 0; k < PART_CNT; k++) begin : g_part
    localparam int PW = (k % 2 == 1) ? HI_W : LO_W;
    localparam int PB = (k / 2) * OFS_W + (k % 2) * LO_W;
    logic [PW-1:0] raw;
    assign raw        = ofsReg[PB +: PW];
    assign partVal[k] = BUS_W'(raw);
  end

  always_ff @(posedge rdClk) begin
    if (rdStrb.clear)     dataOut <= '0;
    else if (rdStrb.step) dataOut <= partVal[rdStrb.rdSel];
  end

  // R6: master reset restores defaults
  p_default_r6: assert property (@(posedge wrClk)
    wrStrb.loadDef |=> (emptyOfs == DEF_V && fullOfs == DEF_V));

  // R2: serial bit enters at the top of the full offset
  p_shift_in_r2: assert property (@(posedge wrClk) disable iff (wrStrb.loadDef)
    wrStrb.shift |=> (fullOfs[OFS_W-1] == $past(serIn)));

  // R4: first part lands in the empty offset low bits
  p_par_lo_r4: assert property (@(posedge wrClk) disable iff (wrStrb.loadDef)
    (wrStrb.parWr && wrStrb.wrSel == '0) |=>
      (emptyOfs[LO_W-1:0] == $past(dataIn[LO_W-1:0])));

  // R5: offsets hold without a load strobe
  p_hold_r5: assert property (@(posedge wrClk) disable iff (wrStrb.loadDef)
    (!wrStrb.shift && !wrStrb.parWr) |=> ($stable(emptyOfs) && $stable(fullOfs)));

  // R8: readback output holds without a step
  p_rd_hold_r8: assert property (@(posedge rdClk) disable iff (rdStrb.clear)
    !rdStrb.step |=> $stable(dataOut));

  // R6: read side cleared by master reset
  p_rd_clear_r6: assert property (@(posedge rdClk)
    rdStrb.clear |=> (dataOut == '0));

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_loader_pkg::*;
#(
  parameter int OFS_W   = 15,
  parameter int BUS_W   = 9,
  parameter int DEF_OFS = 1023
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             mrst,
  input  logic             serialMode,
  input  logic             serEn,
  input  logic             serIn,
  input  logic             loadEn,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [BUS_W-1:0] dataIn,
  output logic [BUS_W-1:0] dataOut,
  output logic [OFS_W-1:0] emptyOfs,
  output logic [OFS_W-1:0] fullOfs
);

  wrStrb_t wrStrb;
  rdStrb_t rdStrb;

  ofs_loader_ctrl u_ctrl (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .mrst       (mrst),
    .serialMode (serialMode),
    .serEn      (serEn),
    .loadEn     (loadEn),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .wrStrb     (wrStrb),
    .rdStrb     (rdStrb)
  );

  ofs_loader_dp #(
    .OFS_W   (OFS_W),
    .BUS_W   (BUS_W),
    .DEF_OFS (DEF_OFS)
  ) u_dp (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .wrStrb   (wrStrb),
    .rdStrb   (rdStrb),
    .serIn    (serIn),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .emptyOfs (emptyOfs),
    .fullOfs  (fullOfs)
  );

endmodule

// File: tb/tb_ofs_loader.sv
module tb_ofs_loader;

  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam logic [14:0] DEF = 15'd1023;

  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  logic mrst = 1'b1;
  logic serialMode = 1'b0;
  logic serEn = 1'b0;
  logic serIn = 1'b0;
  logic loadEn = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [8:0]  dataIn = '0;
  logic [8:0]  dataOut;
  logic [14:0] emptyOfs;
  logic [14:0] fullOfs;

  int checks = 0;
  int fails = 0;

  always #(WCLK_PERIOD/2) wrClk = ~wrClk;
  always #(RCLK_PERIOD/2) rdClk = ~rdClk;

  ofs_loader dut (
    .wrClk(wrClk), .rdClk(rdClk), .mrst(mrst), .serialMode(serialMode),
    .serEn(serEn), .serIn(serIn), .loadEn(loadEn), .wrEn(wrEn), .rdEn(rdEn),
    .dataIn(dataIn), .dataOut(dataOut), .emptyOfs(emptyOfs), .fullOfs(fullOfs)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(logic ser);
    @(negedge wrClk);
    mrst = 1'b1;
    serialMode = ser;
    repeat (3) @(posedge rdClk);
    @(negedge wrClk);
    mrst = 1'b0;
  endtask

  task automatic parWrite(logic [8:0] d, logic le, logic we);
    @(negedge wrClk);
    loadEn = le; wrEn = we; dataIn = d;
    @(negedge wrClk);
    loadEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic serShift(logic b);
    @(negedge wrClk);
    serEn = 1'b1; serIn = b;
    @(negedge wrClk);
    serEn = 1'b0;
  endtask

  task automatic rdStep(logic le, logic re);
    @(negedge rdClk);
    loadEn = le; rdEn = re;
    @(negedge rdClk);
    loadEn = 1'b0; rdEn = 1'b0;
  endtask

  // R6 and R8: reset state in parallel method
  task automatic testReset();
    doReset(1'b0);
    @(negedge rdClk);
    chk("R6 empty default", 32'(emptyOfs), 32'(DEF));
    chk("R6 full default", 32'(fullOfs), 32'(DEF));
    chk("R6 dataOut cleared", 32'(dataOut), 32'h0);
  endtask

  // R4 parallel order, wrap, and upper bus bits ignored for upper parts
  task automatic testParallel();
    parWrite(9'h15C, 1'b1, 1'b1);
    chk("R4 part0 only", 32'(emptyOfs), 32'({DEF[14:9], 9'h15C}));
    chk("R4 full untouched", 32'(fullOfs), 32'(DEF));
    parWrite(9'h1ED, 1'b1, 1'b1);
    parWrite(9'h0A3, 1'b1, 1'b1);
    parWrite(9'h0FF, 1'b1, 1'b1);
    chk("R4 empty full", 32'(emptyOfs), 32'({6'h2D, 9'h15C}));
    chk("R4 full full", 32'(fullOfs), 32'({6'h3F, 9'h0A3}));
    parWrite(9'h011, 1'b1, 1'b1);
    chk("R4 wrap to part0", 32'(emptyOfs), 32'({6'h2D, 9'h011}));
    chk("R4 wrap full kept", 32'(fullOfs), 32'({6'h3F, 9'h0A3}));
  endtask

  // R5 both enables needed; R3 serial ignored in parallel method
  task automatic testIgnored();
    parWrite(9'h1AA, 1'b0, 1'b1);
    parWrite(9'h1AA, 1'b1, 1'b0);
    chk("R5 empty unchanged", 32'(emptyOfs), 32'({6'h2D, 9'h011}));
    chk("R5 full unchanged", 32'(fullOfs), 32'({6'h3F, 9'h0A3}));
    serShift(1'b1); serShift(1'b0); serShift(1'b1);
    chk("R3 serEn ignored empty", 32'(emptyOfs), 32'({6'h2D, 9'h011}));
    chk("R3 serEn ignored full", 32'(fullOfs), 32'({6'h3F, 9'h0A3}));
    // write index is now 1: next write lands in empty upper part
    parWrite(9'h007, 1'b1, 1'b1);
    chk("R5 index kept at 1", 32'(emptyOfs), 32'({6'h07, 9'h011}));
  endtask

  // R7 readback order and wrap, R8 hold, R9 offsets unaffected
  task automatic testReadback();
    logic [14:0] e, f;
    e = emptyOfs; f = fullOfs;
    rdStep(1'b1, 1'b1); chk("R7 read part0", 32'(dataOut), 32'(e[8:0]));
    rdStep(1'b1, 1'b1); chk("R7 read part1", 32'(dataOut), 32'({3'b0, e[14:9]}));
    rdStep(1'b1, 1'b1); chk("R7 read part2", 32'(dataOut), 32'(f[8:0]));
    rdStep(1'b1, 1'b1); chk("R7 read part3", 32'(dataOut), 32'({3'b0, f[14:9]}));
    rdStep(1'b0, 1'b1); chk("R8 hold without loadEn", 32'(dataOut), 32'({3'b0, f[14:9]}));
    rdStep(1'b1, 1'b0); chk("R8 hold without rdEn", 32'(dataOut), 32'({3'b0, f[14:9]}));
    rdStep(1'b1, 1'b1); chk("R7 read wrap", 32'(dataOut), 32'(e[8:0]));
    chk("R9 empty after reads", 32'(emptyOfs), 32'(e));
    chk("R9 full after reads", 32'(fullOfs), 32'(f));
  endtask

  // R1, R2, R3 and R7 in the serial method
  task automatic testSerial();
    logic [14:0] e, f;
    logic [29:0] pat;
    e = 15'h6B2D; f = 15'h1E87;
    pat = {f, e};
    doReset(1'b1);
    serialMode = 1'b0; // R1: must have no effect now
    for (int i = 0; i < 30; i++) serShift(pat[i]);
    chk("R2 serial empty", 32'(emptyOfs), 32'(e));
    chk("R2 serial full", 32'(fullOfs), 32'(f));
    parWrite(9'h000, 1'b1, 1'b1);
    chk("R3 parallel ignored in serial", 32'(emptyOfs), 32'(e));
    serShift(1'b0);
    chk("R1 method still serial", 32'(fullOfs), 32'({1'b0, f[14:1]}));
    chk("R2 chain crosses into empty", 32'(emptyOfs), 32'({f[0], e[14:1]}));
    e = emptyOfs; f = fullOfs;
    rdStep(1'b1, 1'b1); chk("R7 serial read part0", 32'(dataOut), 32'(e[8:0]));
    rdStep(1'b1, 1'b1); chk("R7 serial read part1", 32'(dataOut), 32'({3'b0, e[14:9]}));
  endtask

  // R6 indices cleared, R1 method returns to parallel
  task automatic testReReset();
    doReset(1'b0);
    chk("R6 empty restored", 32'(emptyOfs), 32'(DEF));
    chk("R6 full restored", 32'(fullOfs), 32'(DEF));
    rdStep(1'b1, 1'b1); chk("R6 read index cleared", 32'(dataOut), 32'(DEF[8:0]));
    parWrite(9'h0C3, 1'b1, 1'b1);
    chk("R1 parallel after new reset", 32'(emptyOfs), 32'({DEF[14:9], 9'h0C3}));
  endtask

  initial begin
    testReset();
    testParallel();
    testIgnored();
    testReadback();
    testSerial();
    testReReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(WCLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule